// File: doc/BRIEF.md
# Fast System-Return State Sequencer

This block carries out the return from kernel privilege to user privilege in a processor core. A single start pulse presents the current privilege level, the mode and enable flags, a segment configuration register, the two general-purpose source registers and the user shadow-stack pointer. One cycle later the block reports either a fault code or a complete, registered set of user state. That state is the instruction pointer, the stack pointer, the code and stack selectors, the flat descriptor-cache attributes for both segments, the new privilege level, the shadow-stack pointer and a request to serialize the pipeline.

The selectors are derived arithmetically from the configuration register, and the descriptor caches receive hardwired flat attributes; no descriptor table is read. Fault checks follow a fixed priority: the invalid-opcode causes come first, then every general-protection cause. Mode-dependent checks apply to 64-bit operand size. On a fault the architectural outputs keep their previous values.

Top module: `sret_seq`

## Requirements
- R1: When `lock_i` or `alt_evt_i` is set, the result is fault code 1 (invalid opcode), whatever the other inputs are. Fault codes are: 0 none, 1 invalid opcode, 2 general protection.
- R2: When R1 does not apply, fault code 2 results if `pe_i` is 0, or `cpl_i` is not 0, or the configuration zero test holds. In 32-bit mode that test is `cfg_i[15:2]` all zero. In 64-bit mode (`op64_i`=1) it is the whole of `cfg_i` being zero.
- R3: In 64-bit mode, fault code 2 results if bits 63:47 of `rcx_i` or of `rdx_i` are not all equal. In 32-bit mode, bits 63:32 of both sources have no effect.
- R4: On success, `rsp_o` takes `rcx_i` and `rip_o` takes `rdx_i`. In 32-bit mode both take only bits 31:0, zero-extended.
- R5: On success, `cs_sel_o` = (`cfg_i[15:0]` + 32 in 64-bit mode, + 16 otherwise, modulo 2^16) OR 3, and `ss_sel_o` = `cs_sel_o` + 8.
- R6: The attribute vectors use this layout: [63:32] base, [31:12] limit, [11:8] type, [7] S, [6:5] DPL, [4] P, [3] L, [2] D/B, [1] G, [0] zero. On success, `cs_attr_o` is base 0, limit FFFFF hex, type 11, S=1, DPL=3, P=1, G=1, with L=1 and D=0 in 64-bit mode and L=0 and D=1 otherwise. The resulting values are 64'hFFFFFBFA in 64-bit mode and 64'hFFFFFBF6 otherwise.
- R7: On success, `ss_attr_o` is base 0, limit FFFFF hex, type 3, S=1, DPL=3, P=1, B=1, G=1 (64'hFFFFF3F6).
- R8: On success, `cpl_o` becomes 3. `ssp_o` takes `pl3_ssp_i` when `sstk_en_i` is set and otherwise keeps its value.
- R9: `done_o` is high for exactly one cycle, in the cycle after an accepted start. `fault_o` carries the code only in that cycle and is 0 otherwise. `serialize_o` pulses with `done_o` only when the code is 0.
- R10: When the result is a fault, none of `rip_o`, `rsp_o`, `cs_sel_o`, `ss_sel_o`, `cs_attr_o`, `ss_attr_o`, `cpl_o` or `ssp_o` changes.
- R11: A start pulse that arrives while `done_o` is high is ignored. It produces no further done pulse and no state change.
- R12: Reset clears `done_o`, `fault_o` and `serialize_o`, and sets every state output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| cpl_i | input | 2 | Current privilege level |
| pe_i | input | 1 | Protection enabled |
| alt_evt_i | input | 1 | Alternate event-delivery enabled |
| lock_i | input | 1 | LOCK prefix present |
| op64_i | input | 1 | 64-bit operand size |
| cfg_i | input | CFG_W | Segment configuration register |
| rcx_i | input | ADDR_W | Stack-pointer source |
| rdx_i | input | ADDR_W | Instruction-pointer source |
| sstk_en_i | input | 1 | Shadow stacks enabled at level 3 |
| pl3_ssp_i | input | ADDR_W | User shadow-stack pointer register |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | Fault code, valid with done |
| serialize_o | output | 1 | Serialize request |
| rip_o | output | ADDR_W | Instruction pointer |
| rsp_o | output | ADDR_W | Stack pointer |
| cs_sel_o | output | 16 | Code selector |
| ss_sel_o | output | 16 | Stack selector |
| cs_attr_o | output | 64 | Code descriptor-cache attributes |
| ss_attr_o | output | 64 | Stack descriptor-cache attributes |
| cpl_o | output | 2 | Privilege level |
| ssp_o | output | ADDR_W | Shadow-stack pointer |

## Verification
The in-RTL properties check several rules on every cycle. The done pulse never lasts two cycles. Serialize appears only with a clean completion. A faulting completion leaves the state registers untouched, and an ignored start causes no state change. Every successful completion carries the forced requested-privilege bits, the stack selector eight above the code selector, privilege level 3, and invalid-opcode precedence.

Some behaviour depends on exact input values, and only the bench scenarios show it. These cases are the exact selector arithmetic including 16-bit wrap, the different zero test in each mode, the canonical boundary at bit 47, the discarded upper halves in 32-bit mode, and the conditional shadow-stack load.

// File: rtl/sret_pkg.sv
package sret_pkg;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_UD   = 2'd1,
      FLT_GP   = 2'd2
   } flt_e;

   typedef struct packed {
      logic [31:0] base;
      logic [19:0] limit;
      logic [3:0]  typ;
      logic        s;
      logic [1:0]  dpl;
      logic        p;
      logic        l;
      logic        db;
      logic        g;
      logic        rsvd;
   } seg_attr_t;

   localparam logic [3:0] CODE_TYPE = 4'd11;
   localparam logic [3:0] DATA_TYPE = 4'd3;
   localparam logic [1:0] USER_PL   = 2'd3;

endpackage

// File: rtl/sret_canon.sv
module sret_canon #(
   parameter int HI_W = 17
) (
   input  logic [HI_W-1:0] hi_bits,
   output logic            ok
);
   generate
      if (HI_W <= 1) begin : g_full_width
         assign ok = 1'b1;
      end else begin : g_sign_ext
         assign ok = (&hi_bits) | ~(|hi_bits);
      end
   endgenerate
endmodule

// File: rtl/sret_fault_chk.sv
module sret_fault_chk
   import sret_pkg::*;
#(
   parameter int CFG_W = 32,
   parameter int HI_W  = 17
) (
   input  logic [1:0]      cpl,
   input  logic            pe,
   input  logic            alt_evt,
   input  logic            lock,
   input  logic            op64,
   input  logic [CFG_W-1:0] cfg,
   input  logic [HI_W-1:0] rcx_hi,
   input  logic [HI_W-1:0] rdx_hi,
   output flt_e            code
);
   logic rcx_ok, rdx_ok;
   logic cfg_zero, canon_bad, ud_hit, gp_hit;

   sret_canon #(.HI_W(HI_W)) u_canon_sp (.hi_bits(rcx_hi), .ok(rcx_ok));
   sret_canon #(.HI_W(HI_W)) u_canon_ip (.hi_bits(rdx_hi), .ok(rdx_ok));

   always_comb begin
      cfg_zero  = op64 ? (cfg == '0) : (cfg[15:2] == '0);
      canon_bad = op64 & ~(rcx_ok & rdx_ok);
      ud_hit    = lock | alt_evt;
      gp_hit    = cfg_zero | ~pe | (cpl != 2'd0) | canon_bad;
      if (ud_hit)      code = FLT_UD;
      else if (gp_hit) code = FLT_GP;
      else             code = FLT_NONE;
   end
endmodule

// File: rtl/sret_state_gen.sv
module sret_state_gen
   import sret_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int CFG_W  = 32,
   parameter int SEL_W  = 16
) (
   input  logic              op64,
   input  logic [CFG_W-1:0]  cfg,
   input  logic [ADDR_W-1:0] rcx,
   input  logic [ADDR_W-1:0] rdx,
   output logic [ADDR_W-1:0] rip_n,
   output logic [ADDR_W-1:0] rsp_n,
   output logic [SEL_W-1:0]  cs_sel_n,
   output logic [SEL_W-1:0]  ss_sel_n,
   output seg_attr_t         cs_attr_n,
   output seg_attr_t         ss_attr_n
);
   localparam int LEG_W = 32;
   localparam logic [SEL_W-1:0] OFS_WIDE = SEL_W'(32);
   localparam logic [SEL_W-1:0] OFS_LEG  = SEL_W'(16);
   localparam logic [SEL_W-1:0] OFS_STK  = SEL_W'(8);
   localparam logic [SEL_W-1:0] RPL_MASK = SEL_W'(3);

   logic [SEL_W-1:0] sel_sum;

   always_comb begin
      rsp_n    = op64 ? rcx : {{(ADDR_W-LEG_W){1'b0}}, rcx[LEG_W-1:0]};
      rip_n    = op64 ? rdx : {{(ADDR_W-LEG_W){1'b0}}, rdx[LEG_W-1:0]};
      sel_sum  = cfg[SEL_W-1:0] + (op64 ? OFS_WIDE : OFS_LEG);
      cs_sel_n = sel_sum | RPL_MASK;
      ss_sel_n = cs_sel_n + OFS_STK;

      cs_attr_n       = '0;
      cs_attr_n.limit = '1;
      cs_attr_n.typ   = CODE_TYPE;
      cs_attr_n.s     = 1'b1;
      cs_attr_n.dpl   = USER_PL;
      cs_attr_n.p     = 1'b1;
      cs_attr_n.l     = op64;
      cs_attr_n.db    = ~op64;
      cs_attr_n.g     = 1'b1;

      ss_attr_n       = '0;
      ss_attr_n.limit = '1;
      ss_attr_n.typ   = DATA_TYPE;
      ss_attr_n.s     = 1'b1;
      ss_attr_n.dpl   = USER_PL;
      ss_attr_n.p     = 1'b1;
      ss_attr_n.db    = 1'b1;
      ss_attr_n.g     = 1'b1;
   end
endmodule

// File: rtl/sret_seq.sv
module sret_seq
   import sret_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int VA_BITS = 48,
   parameter int CFG_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        cpl_i,
   input  logic              pe_i,
   input  logic              alt_evt_i,
   input  logic              lock_i,
   input  logic              op64_i,
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic [ADDR_W-1:0] rcx_i,
   input  logic [ADDR_W-1:0] rdx_i,
   input  logic              sstk_en_i,
   input  logic [ADDR_W-1:0] pl3_ssp_i,
   output logic              done_o,
   output logic [1:0]        fault_o,
   output logic              serialize_o,
   output logic [ADDR_W-1:0] rip_o,
   output logic [ADDR_W-1:0] rsp_o,
   output logic [15:0]       cs_sel_o,
   output logic [15:0]       ss_sel_o,
   output logic [63:0]       cs_attr_o,
   output logic [63:0]       ss_attr_o,
   output logic [1:0]        cpl_o,
   output logic [ADDR_W-1:0] ssp_o
);
   localparam int SEL_W = 16;
   localparam int HI_W  = ADDR_W - VA_BITS + 1;

   generate
      if (ADDR_W <= 32 || VA_BITS > ADDR_W || VA_BITS < 2 || CFG_W < SEL_W) begin : g_param_bad
         $error("sret_seq: unsupported parameter combination");
      end
   endgenerate

   flt_e              code;
   logic [ADDR_W-1:0] rip_n, rsp_n;
   logic [SEL_W-1:0]  cs_sel_n, ss_sel_n;
   seg_attr_t         cs_attr_n, ss_attr_n;

   sret_fault_chk #(.CFG_W(CFG_W), .HI_W(HI_W)) u_fault (
      .cpl     (cpl_i),
      .pe      (pe_i),
      .alt_evt (alt_evt_i),
      .lock    (lock_i),
      .op64    (op64_i),
      .cfg     (cfg_i),
      .rcx_hi  (rcx_i[ADDR_W-1:VA_BITS-1]),
      .rdx_hi  (rdx_i[ADDR_W-1:VA_BITS-1]),
      .code    (code)
   );

   sret_state_gen #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .SEL_W(SEL_W)) u_state (
      .op64      (op64_i),
      .cfg       (cfg_i),
      .rcx       (rcx_i),
      .rdx       (rdx_i),
      .rip_n     (rip_n),
      .rsp_n     (rsp_n),
      .cs_sel_n  (cs_sel_n),
      .ss_sel_n  (ss_sel_n),
      .cs_attr_n (cs_attr_n),
      .ss_attr_n (ss_attr_n)
   );

   logic accept, commit;
   assign accept = start_i & ~done_o;
   assign commit = accept & (code == FLT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         fault_o     <= FLT_NONE;
         serialize_o <= 1'b0;
         rip_o       <= '0;
         rsp_o       <= '0;
         cs_sel_o    <= '0;
         ss_sel_o    <= '0;
         cs_attr_o   <= '0;
         ss_attr_o   <= '0;
         cpl_o       <= '0;
         ssp_o       <= '0;
      end else begin
         done_o      <= accept;
         fault_o     <= accept ? code : FLT_NONE;
         serialize_o <= commit;
         if (commit) begin
            rip_o     <= rip_n;
            rsp_o     <= rsp_n;
            cs_sel_o  <= cs_sel_n;
            ss_sel_o  <= ss_sel_n;
            cs_attr_o <= cs_attr_n;
            ss_attr_o <= ss_attr_n;
            cpl_o     <= USER_PL;
            if (sstk_en_i) ssp_o <= pl3_ssp_i;
         end
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   serialize_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serialize_o |-> (done_o && fault_o == FLT_NONE));

   // R10
   hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o != FLT_NONE) |-> ($stable(rip_o) && $stable(rsp_o) &&
         $stable(cs_sel_o) && $stable(ss_sel_o) && $stable(cpl_o) && $stable(ssp_o)));

   // R5
   selector_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serialize_o |-> (ss_sel_o == cs_sel_o + 16'd8 && cs_sel_o[1:0] == 2'b11));

   // R8
   user_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serialize_o |-> cpl_o == 2'd3);

   // R1
   ud_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !done_o && (lock_i || alt_evt_i)) |=> fault_o == FLT_UD);

   // R11
   ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && done_o) |=> (!done_o && $stable(rip_o) && $stable(rsp_o)));

   // R9
   fault_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o != 2'b11);

endmodule

// File: tb/tb_sret_seq.sv
module tb_sret_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  cpl_i = '0;
   logic        pe_i = 1'b0, alt_evt_i = 1'b0, lock_i = 1'b0, op64_i = 1'b0, sstk_en_i = 1'b0;
   logic [31:0] cfg_i = '0;
   logic [63:0] rcx_i = '0, rdx_i = '0, pl3_ssp_i = '0;
   logic        done_o, serialize_o;
   logic [1:0]  fault_o, cpl_o;
   logic [63:0] rip_o, rsp_o, cs_attr_o, ss_attr_o, ssp_o;
   logic [15:0] cs_sel_o, ss_sel_o;

   always #2 clk = ~clk;

   sret_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpl_i(cpl_i), .pe_i(pe_i),
      .alt_evt_i(alt_evt_i), .lock_i(lock_i), .op64_i(op64_i), .cfg_i(cfg_i),
      .rcx_i(rcx_i), .rdx_i(rdx_i), .sstk_en_i(sstk_en_i), .pl3_ssp_i(pl3_ssp_i),
      .done_o(done_o), .fault_o(fault_o), .serialize_o(serialize_o),
      .rip_o(rip_o), .rsp_o(rsp_o), .cs_sel_o(cs_sel_o), .ss_sel_o(ss_sel_o),
      .cs_attr_o(cs_attr_o), .ss_attr_o(ss_attr_o), .cpl_o(cpl_o), .ssp_o(ssp_o)
   );

   typedef struct packed {
      logic [1:0]  cpl;
      logic        pe, alt, lock, op64, sse;
      logic [31:0] cfg;
      logic [63:0] rcx, rdx, ssp;
      logic [1:0]  efault;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [0:NV-1] = '{
      '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0000_0010,64'hFFFF_FFFF_1234_5678,64'hAAAA_0000_0040_1000,64'h1111,2'd0},
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0000_0010,64'h0000_7FFF_FFFF_F000,64'hFFFF_8000_0000_0000,64'h1111,2'd0},
      '{2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,32'h0000_0000,64'h10,64'h20,64'h1111,2'd1},
      '{2'd0,1'b0,1'b1,1'b0,1'b1,1'b0,32'h0000_0010,64'h8000_0000_0000_0000,64'h20,64'h1111,2'd1},
      '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0000_0003,64'h10,64'h20,64'h1111,2'd2},
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0000_0003,64'h0000_0000_0000_3000,64'h0000_0000_0000_4000,64'h1111,2'd0},
      '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0001_0000,64'h30,64'h40,64'h1111,2'd2},
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0001_0000,64'h50,64'h60,64'h1111,2'd0},
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0000_0010,64'h70,64'h80,64'h1111,2'd2},
      '{2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0000_0010,64'h70,64'h80,64'h1111,2'd2},
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0000_0010,64'h0000_8000_0000_0000,64'h80,64'h1111,2'd2},
      '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0000_0010,64'h0000_8000_0000_0100,64'h5555_0000_0000_0200,64'h1111,2'd0},
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0000_FFF0,64'hFFFF_FFFF_FFFF_FF00,64'h0000_0000_0000_0900,64'h0000_7000_0000_0008,2'd0},
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0000_0010,64'h90,64'hFFFF_0000_0000_0000,64'h1111,2'd2}
   };

   int checks = 0, fails = 0;
   logic [63:0] e_rip = '0, e_rsp = '0, e_csa = '0, e_ssa = '0, e_ssp = '0;
   logic [15:0] e_cs = '0, e_ss = '0;
   logic [1:0]  e_cpl = '0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_state();
      chk("R4 rip", rip_o, e_rip);
      chk("R4 rsp", rsp_o, e_rsp);
      chk("R5 cs", {48'd0, cs_sel_o}, {48'd0, e_cs});
      chk("R5 ss", {48'd0, ss_sel_o}, {48'd0, e_ss});
      chk("R6 cs_attr", cs_attr_o, e_csa);
      chk("R7 ss_attr", ss_attr_o, e_ssa);
      chk("R8 cpl", {62'd0, cpl_o}, {62'd0, e_cpl});
      chk("R8 ssp", ssp_o, e_ssp);
   endtask

   task automatic drive(input vec_t v);
      cpl_i = v.cpl; pe_i = v.pe; alt_evt_i = v.alt; lock_i = v.lock;
      op64_i = v.op64; sstk_en_i = v.sse; cfg_i = v.cfg;
      rcx_i = v.rcx; rdx_i = v.rdx; pl3_ssp_i = v.ssp;
   endtask

   task automatic expect_success(input vec_t v);
      e_rsp = v.op64 ? v.rcx : {32'd0, v.rcx[31:0]};
      e_rip = v.op64 ? v.rdx : {32'd0, v.rdx[31:0]};
      e_cs  = (v.cfg[15:0] + (v.op64 ? 16'd32 : 16'd16)) | 16'h0003;
      e_ss  = e_cs + 16'd8;
      e_csa = v.op64 ? 64'h0000_0000_FFFF_FBFA : 64'h0000_0000_FFFF_FBF6;
      e_ssa = 64'h0000_0000_FFFF_F3F6;
      e_cpl = 2'd3;
      if (v.sse) e_ssp = v.ssp;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 done", {63'd0, done_o}, 64'd0);
      chk("R12 fault", {62'd0, fault_o}, 64'd0);
      chk("R12 serialize", {63'd0, serialize_o}, 64'd0);
      chk_state();
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         if (VEC[i].efault == 2'd0) expect_success(VEC[i]);
         // R1 R2 R3 fault code, R9 pulse, R10 hold on fault
         chk("R1/R2/R3 fault", {62'd0, fault_o}, {62'd0, VEC[i].efault});
         chk("R9 done", {63'd0, done_o}, 64'd1);
         chk("R9 serialize", {63'd0, serialize_o}, {63'd0, VEC[i].efault == 2'd0});
         chk_state();
         @(negedge clk);
         chk("R9 done drops", {63'd0, done_o}, 64'd0);
         chk("R9 fault drops", {62'd0, fault_o}, 64'd0);
      end

      // R11: second start while done is high is ignored
      drive(VEC[0]);
      rdx_i = 64'h0000_0000_0000_0ABC;
      start_i = 1'b1;
      @(negedge clk);
      expect_success(VEC[0]);
      e_rip = 64'h0000_0000_0000_0ABC;
      chk("R11 first done", {63'd0, done_o}, 64'd1);
      rdx_i = 64'h0000_0000_0000_0DEF;
      @(negedge clk);
      start_i = 1'b0;
      chk("R11 no second done", {63'd0, done_o}, 64'd0);
      chk("R11 rip kept", rip_o, e_rip);

      // R12 reset again mid-run clears state
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R12 rip cleared", rip_o, 64'd0);
      chk("R12 cpl cleared", {62'd0, cpl_o}, 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule